// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves one control-flow instruction of a 64-bit register machine whose program is laid out in 64-bit slots. It receives the opcode, the two register operands, the 32-bit immediate, the signed 16-bit displacement and the slot index of the instruction. One cycle later it reports four things: whether the branch is taken, the next slot, whether the opcode is unusable, and whether a taken target falls outside a slot window set by the caller.

Bit 3 of the opcode selects the second comparison operand. Bits 7:4 select the condition. The unit does not handle calls or returns. It flags them for an outside sequencer and leaves the slot index unchanged. Register reads and memory access happen elsewhere.

Top module: `branch_resolve_unit`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high and is low otherwise. Reset clears `out_valid`, `out_taken` and all four flags.
- R2: Opcode bit 3 picks the second operand. When it is 0, the operand is the immediate sign-extended to 64 bits. When it is 1, the operand is `in_src`.
- R3: Condition code 0 (opcode 0x05) is always taken. Code 1 takes on equality. Code 5 takes on inequality. Code 4 takes when the bitwise AND of the two operands is non-zero.
- R4: Codes 2, 3, 0xA and 0xB compare the operands as unsigned 64-bit values, testing greater, greater-or-equal, less and less-or-equal in that order. An immediate is sign-extended before these compares as well.
- R5: Codes 6, 7, 0xC and 0xD compare the operands as signed 64-bit values, testing greater, greater-or-equal, less and less-or-equal in that order.
- R6: A taken branch gives a next slot of slot + 1 + sign-extended offset. A branch that is not taken gives slot + 1.
- R7: A taken target below `in_lo_bound` or above `in_hi_bound` sets `out_range_err` and holds `out_next_slot` at the current slot. `out_taken` still shows the condition result. Both bounds are inclusive.
- R8: The following opcodes set `out_bad_opcode`, clear `out_taken` and hold `out_next_slot` at the current slot:
  - any opcode whose bits 2:0 are not 3'b101;
  - 0x0D, 0x9D, 0xE5, 0xED, 0xF5 and 0xFD.
- R9: Opcodes 0x85 and 0x8D set `out_call_req`. Opcode 0x95 sets `out_ret_req`. In both cases no condition is evaluated, `out_taken` is 0 and `out_next_slot` holds the current slot.
- R10: Of `out_bad_opcode`, `out_range_err`, `out_call_req` and `out_ret_req`, at most one is high in any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction strobe |
| in_opcode | input | 8 | Opcode byte |
| in_dst | input | 64 | First operand register value |
| in_src | input | 64 | Second operand register value |
| in_imm | input | 32 | Immediate field |
| in_off | input | 16 | Signed slot displacement |
| in_slot | input | SLOT_W | Slot index of the instruction |
| in_lo_bound | input | SLOT_W | Lowest allowed target slot |
| in_hi_bound | input | SLOT_W | Highest allowed target slot |
| out_valid | output | 1 | Result strobe |
| out_taken | output | 1 | Condition held |
| out_next_slot | output | SLOT_W | Next program slot |
| out_bad_opcode | output | 1 | Unusable opcode |
| out_range_err | output | 1 | Taken target outside the window |
| out_call_req | output | 1 | Call for the sequencer |
| out_ret_req | output | 1 | Return for the sequencer |

## Verification
The second operand is tested with equal immediates but different register values, so a wrong operand source flips the outcome.

Unsigned compares use an immediate of all ones. The result differs depending on whether the immediate is sign- or zero-extended. Signed compares use a negative register value, which orders differently under a signed and an unsigned reading.

Targets are placed exactly on each bound, one slot past each bound, and below slot zero. These cases separate inclusive checks from exclusive ones and catch wrap-around.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    KIND_BRANCH = 2'd0,
    KIND_CALL   = 2'd1,
    KIND_RETURN = 2'd2,
    KIND_BAD    = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    CND_ALWAYS = 4'h0,
    CND_EQ     = 4'h1,
    CND_UGT    = 4'h2,
    CND_UGE    = 4'h3,
    CND_ANY    = 4'h4,
    CND_NE     = 4'h5,
    CND_SGT    = 4'h6,
    CND_SGE    = 4'h7,
    CND_CALL   = 4'h8,
    CND_RET    = 4'h9,
    CND_ULT    = 4'hA,
    CND_ULE    = 4'hB,
    CND_SLT    = 4'hC,
    CND_SLE    = 4'hD
  } cond_e;

  localparam logic [2:0] FLOW_CLASS = 3'b101;
endpackage

// File: rtl/brk_decode.sv
module brk_decode
  import brk_pkg::*;
(
  input  logic [7:0] opcode,
  output kind_e      kind,
  output logic [3:0] cond,
  output logic       use_reg
);
  logic       reg_sel;
  logic [3:0] code;

  assign reg_sel = opcode[3];
  assign code    = opcode[7:4];
  assign cond    = code;
  assign use_reg = reg_sel;

  always_comb begin
    kind = KIND_BRANCH;
    if (opcode[2:0] != FLOW_CLASS) begin
      kind = KIND_BAD;
    end else begin
      unique case (code)
        4'h0:    kind = reg_sel ? KIND_BAD : KIND_BRANCH;
        4'h8:    kind = KIND_CALL;
        4'h9:    kind = reg_sel ? KIND_BAD : KIND_RETURN;
        4'hE,
        4'hF:    kind = KIND_BAD;
        default: kind = KIND_BRANCH;
      endcase
    end
  end
endmodule

// File: rtl/brk_cond_eval.sv
module brk_cond_eval
  import brk_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic [3:0]        cond,
  input  logic              use_reg,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs_reg,
  input  logic [IMM_W-1:0]  rhs_imm,
  output logic              hit
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] rhs;
  logic eq, ult, slt, any;

  assign rhs = use_reg ? rhs_reg : {{EXT_W{rhs_imm[IMM_W-1]}}, rhs_imm};
  assign eq  = (lhs == rhs);
  assign ult = (lhs < rhs);
  assign slt = ($signed(lhs) < $signed(rhs));
  assign any = |(lhs & rhs);

  always_comb begin
    unique case (cond)
      CND_ALWAYS: hit = 1'b1;
      CND_EQ:     hit = eq;
      CND_UGT:    hit = !ult && !eq;
      CND_UGE:    hit = !ult;
      CND_ANY:    hit = any;
      CND_NE:     hit = !eq;
      CND_SGT:    hit = !slt && !eq;
      CND_SGE:    hit = !slt;
      CND_ULT:    hit = ult;
      CND_ULE:    hit = ult || eq;
      CND_SLT:    hit = slt;
      CND_SLE:    hit = slt || eq;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/brk_target_calc.sv
module brk_target_calc #(
  parameter int SLOT_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [OFF_W-1:0]  off,
  input  logic [SLOT_W-1:0] lo_bound,
  input  logic [SLOT_W-1:0] hi_bound,
  output logic [SLOT_W-1:0] seq_slot,
  output logic [SLOT_W-1:0] jump_slot,
  output logic              outside
);
  localparam int EW = SLOT_W + 2;

  logic signed [EW-1:0] base, step, tgt, lo_s, hi_s;

  assign base      = $signed({2'b00, slot});
  assign step      = $signed({{(EW-OFF_W){off[OFF_W-1]}}, off});
  assign lo_s      = $signed({2'b00, lo_bound});
  assign hi_s      = $signed({2'b00, hi_bound});
  assign tgt       = base + step + EW'(1);
  assign seq_slot  = slot + SLOT_W'(1);
  assign jump_slot = tgt[SLOT_W-1:0];
  assign outside   = (tgt < lo_s) || (tgt > hi_s);
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brk_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_opcode,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [OFF_W-1:0]  in_off,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [SLOT_W-1:0] in_lo_bound,
  input  logic [SLOT_W-1:0] in_hi_bound,
  output logic              out_valid,
  output logic              out_taken,
  output logic [SLOT_W-1:0] out_next_slot,
  output logic              out_bad_opcode,
  output logic              out_range_err,
  output logic              out_call_req,
  output logic              out_ret_req
);
  kind_e             kind;
  logic [3:0]        cond;
  logic              use_reg, hit, outside;
  logic [SLOT_W-1:0] seq_slot, jump_slot;

  logic              nx_taken, nx_bad, nx_range, nx_call, nx_ret;
  logic [SLOT_W-1:0] nx_slot;

  brk_decode i_decode (
    .opcode  (in_opcode),
    .kind    (kind),
    .cond    (cond),
    .use_reg (use_reg)
  );

  brk_cond_eval #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_cond (
    .cond    (cond),
    .use_reg (use_reg),
    .lhs     (in_dst),
    .rhs_reg (in_src),
    .rhs_imm (in_imm),
    .hit     (hit)
  );

  brk_target_calc #(.SLOT_W(SLOT_W), .OFF_W(OFF_W)) i_target (
    .slot      (in_slot),
    .off       (in_off),
    .lo_bound  (in_lo_bound),
    .hi_bound  (in_hi_bound),
    .seq_slot  (seq_slot),
    .jump_slot (jump_slot),
    .outside   (outside)
  );

  always_comb begin
    nx_taken = 1'b0;
    nx_bad   = 1'b0;
    nx_range = 1'b0;
    nx_call  = 1'b0;
    nx_ret   = 1'b0;
    nx_slot  = in_slot;
    unique case (kind)
      KIND_BRANCH: begin
        nx_taken = hit;
        nx_range = hit && outside;
        if (!hit)         nx_slot = seq_slot;
        else if (!outside) nx_slot = jump_slot;
      end
      KIND_CALL:   nx_call = 1'b1;
      KIND_RETURN: nx_ret  = 1'b1;
      default:     nx_bad  = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_taken      <= 1'b0;
      out_next_slot  <= '0;
      out_bad_opcode <= 1'b0;
      out_range_err  <= 1'b0;
      out_call_req   <= 1'b0;
      out_ret_req    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken      <= nx_taken;
        out_next_slot  <= nx_slot;
        out_bad_opcode <= nx_bad;
        out_range_err  <= nx_range;
        out_call_req   <= nx_call;
        out_ret_req    <= nx_ret;
      end
    end
  end
endmodule

// File: rtl/brk_checker.sv
module brk_checker #(
  parameter int SLOT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [SLOT_W-1:0] in_slot,
  input logic [SLOT_W-1:0] in_lo_bound,
  input logic [SLOT_W-1:0] in_hi_bound,
  input logic              out_valid,
  input logic              out_taken,
  input logic [SLOT_W-1:0] out_next_slot,
  input logic              out_bad_opcode,
  input logic              out_range_err,
  input logic              out_call_req,
  input logic              out_ret_req
);
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({out_bad_opcode, out_range_err, out_call_req, out_ret_req})); // R10
  AST_BAD_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_bad_opcode || out_call_req || out_ret_req)) |-> !out_taken); // R8
  AST_RANGE_HOLDS_SLOT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_range_err -> (out_next_slot == $past(in_slot)))); // R7
  AST_TAKEN_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_taken && !out_range_err) ->
      (out_next_slot >= $past(in_lo_bound) && out_next_slot <= $past(in_hi_bound)))); // R7
  AST_FALLTHROUGH_STEP: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((!out_taken && !out_bad_opcode && !out_call_req && !out_ret_req) ->
      (out_next_slot == $past(in_slot) + SLOT_W'(1)))); // R6
endmodule

bind branch_resolve_unit brk_checker #(.SLOT_W(SLOT_W)) i_brk_checker (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_slot        (in_slot),
  .in_lo_bound    (in_lo_bound),
  .in_hi_bound    (in_hi_bound),
  .out_valid      (out_valid),
  .out_taken      (out_taken),
  .out_next_slot  (out_next_slot),
  .out_bad_opcode (out_bad_opcode),
  .out_range_err  (out_range_err),
  .out_call_req   (out_call_req),
  .out_ret_req    (out_ret_req)
);

// File: tb/test_branch_resolve_unit.sv
module test_branch_resolve_unit;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_opcode = '0;
  logic [63:0]   in_dst = '0, in_src = '0;
  logic [31:0]   in_imm = '0;
  logic [15:0]   in_off = '0;
  logic [SW-1:0] in_slot = '0, in_lo_bound = '0, in_hi_bound = '0;
  logic          out_valid, out_taken, out_bad_opcode, out_range_err, out_call_req, out_ret_req;
  logic [SW-1:0] out_next_slot;

  int errors = 0;
  int checks = 0;

  typedef struct packed {
    logic          taken;
    logic [SW-1:0] nxt;
    logic          bad, rng, call, ret;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  branch_resolve_unit #(.SLOT_W(SW)) i_branch_resolve_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm), .in_off(in_off),
    .in_slot(in_slot), .in_lo_bound(in_lo_bound), .in_hi_bound(in_hi_bound),
    .out_valid(out_valid), .out_taken(out_taken), .out_next_slot(out_next_slot),
    .out_bad_opcode(out_bad_opcode), .out_range_err(out_range_err),
    .out_call_req(out_call_req), .out_ret_req(out_ret_req)
  );

  function automatic exp_t model(input logic [7:0] op, input logic [63:0] a, input logic [63:0] s,
                                 input logic [31:0] im, input logic [15:0] of,
                                 input logic [SW-1:0] sl, input logic [SW-1:0] lo, input logic [SW-1:0] hi);
    exp_t e;
    logic [63:0] b;
    logic c;
    longint t;
    e = '0;
    e.nxt = sl;
    b = op[3] ? s : {{32{im[31]}}, im};
    c = 1'b0;
    if (op[2:0] != 3'b101 || op == 8'h0D || op == 8'h9D || op[7:4] >= 4'hE) begin
      e.bad = 1'b1;
      return e;
    end
    if (op[7:4] == 4'h8) begin e.call = 1'b1; return e; end
    if (op[7:4] == 4'h9) begin e.ret  = 1'b1; return e; end
    case (op[7:4])
      4'h0: c = 1'b1;
      4'h1: c = (a == b);
      4'h2: c = (a > b);
      4'h3: c = (a >= b);
      4'h4: c = ((a & b) != 0);
      4'h5: c = (a != b);
      4'h6: c = ($signed(a) > $signed(b));
      4'h7: c = ($signed(a) >= $signed(b));
      4'hA: c = (a < b);
      4'hB: c = (a <= b);
      4'hC: c = ($signed(a) < $signed(b));
      4'hD: c = ($signed(a) <= $signed(b));
      default: c = 1'b0;
    endcase
    e.taken = c;
    if (!c) begin
      e.nxt = sl + 1;
    end else begin
      t = longint'(sl) + 1 + longint'($signed(of));
      if (t < longint'(lo) || t > longint'(hi)) e.rng = 1'b1;
      else e.nxt = t[SW-1:0];
    end
    return e;
  endfunction

  task automatic drive(input string tag, input logic [7:0] op, input logic [63:0] a, input logic [63:0] s,
                       input logic [31:0] im, input logic [15:0] of, input logic [SW-1:0] sl);
    @(negedge clk);
    in_valid  = 1'b1;
    in_opcode = op; in_dst = a; in_src = s; in_imm = im; in_off = of; in_slot = sl;
    exp_q.push_back(model(op, a, s, im, of, sl, in_lo_bound, in_hi_bound));
    tag_q.push_back(tag);
  endtask

  // Monitor: one result per strobe, compared against the queued expectation.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t  e;
      string tg;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected result: actual out_valid=1 expected out_valid=0");
      end else begin
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        if ({out_taken, out_next_slot, out_bad_opcode, out_range_err, out_call_req, out_ret_req} !== e) begin
          errors++;
          $display("FAIL %s actual taken=%0b next=%0d bad=%0b rng=%0b call=%0b ret=%0b expected taken=%0b next=%0d bad=%0b rng=%0b call=%0b ret=%0b",
                   tg, out_taken, out_next_slot, out_bad_opcode, out_range_err, out_call_req, out_ret_req,
                   e.taken, e.nxt, e.bad, e.rng, e.call, e.ret);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual run still busy expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    in_lo_bound = 10;
    in_hi_bound = 1000;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_taken !== 1'b0 || out_bad_opcode !== 1'b0 || out_range_err !== 1'b0
        || out_call_req !== 1'b0 || out_ret_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual valid=%0b taken=%0b expected 0 0", out_valid, out_taken);
    end
    rst = 1'b0;

    drive("R3 always", 8'h05, 64'd0, 64'd0, 32'd0, 16'd5, 100);
    drive("R3 eq imm hit", 8'h15, 64'd42, 64'd0, 32'd42, 16'd3, 100);
    drive("R3 ne imm miss", 8'h55, 64'd42, 64'd0, 32'd42, 16'd3, 100);
    drive("R3 jset reg", 8'h4D, 64'h10, 64'h30, 32'd0, 16'd7, 100);
    drive("R3 jset imm miss", 8'h45, 64'h10, 64'h0, 32'h01, 16'd7, 100);
    drive("R2 reg operand", 8'h1D, 64'd5, 64'd7, 32'd5, 16'd4, 100);
    drive("R2 imm operand", 8'h15, 64'd5, 64'd7, 32'd5, 16'd4, 100);
    drive("R2 imm sign ext eq", 8'h15, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 32'hFFFF_FFFE, 16'd2, 100);
    drive("R4 uge sext imm", 8'h35, 64'h0000_0000_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 16'd9, 100);
    drive("R4 ult sext imm", 8'hA5, 64'h0000_0000_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 16'd9, 100);
    drive("R4 ugt reg", 8'h2D, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 16'd1, 100);
    drive("R4 ule reg equal", 8'hBD, 64'd9, 64'd9, 32'd0, 16'd1, 100);
    drive("R5 sgt negative", 8'h65, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'd1, 16'd2, 100);
    drive("R5 slt negative", 8'hCD, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, 16'd2, 100);
    drive("R5 sge equal", 8'h75, 64'hFFFF_FFFF_FFFF_FFF0, 64'd0, 32'hFFFF_FFF0, 16'd2, 100);
    drive("R5 sle reg", 8'hDD, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 16'd2, 100);
    drive("R6 negative offset", 8'h05, 64'd0, 64'd0, 32'd0, 16'hFFCE, 100);
    drive("R6 not taken step", 8'h1D, 64'd1, 64'd2, 32'd0, 16'd50, 100);
    drive("R7 above window", 8'h05, 64'd0, 64'd0, 32'd0, 16'd2000, 100);
    drive("R7 below zero", 8'h05, 64'd0, 64'd0, 32'd0, 16'hFF38, 100);
    drive("R7 on upper bound", 8'h05, 64'd0, 64'd0, 32'd0, 16'd0, 999);
    drive("R7 one past upper", 8'h05, 64'd0, 64'd0, 32'd0, 16'd1, 999);
    drive("R7 on lower bound", 8'h05, 64'd0, 64'd0, 32'd0, 16'hFFFF, 10);
    drive("R7 one below lower", 8'h05, 64'd0, 64'd0, 32'd0, 16'hFFFE, 10);
    drive("R7 untaken ignores window", 8'h15, 64'd1, 64'd0, 32'd2, 16'd2000, 100);
    drive("R8 reserved 0D", 8'h0D, 64'd0, 64'd0, 32'd0, 16'd5, 100);
    drive("R8 reserved 9D", 8'h9D, 64'd0, 64'd0, 32'd0, 16'd5, 100);
    drive("R8 reserved E5", 8'hE5, 64'd0, 64'd0, 32'd0, 16'd5, 100);
    drive("R8 reserved FD", 8'hFD, 64'd0, 64'd0, 32'd0, 16'd5, 100);
    drive("R8 other class", 8'h07, 64'd0, 64'd0, 32'd0, 16'd5, 100);
    drive("R9 call", 8'h85, 64'd0, 64'd0, 32'd0, 16'd5, 100);
    drive("R9 call reg", 8'h8D, 64'd0, 64'd0, 32'd0, 16'd5, 100);
    drive("R9 return", 8'h95, 64'd0, 64'd0, 32'd0, 16'd5, 100);
    drive("R10 range only", 8'h05, 64'd0, 64'd0, 32'd0, 16'd3000, 500);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    // R1: every strobe produced exactly one result
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results: actual pending=%0d expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule